// File: doc/BRIEF.md
# Command Packet Framer (Transmit)

This block turns a command request from the host into a framed byte stream for the transmit FIFO of a serial master. A frame is a fixed marker byte, a command byte, a length byte, the payload bytes and two check bytes. The block computes the check bytes while the earlier bytes stream out, so the frame needs no second pass. The host either loads the payload into a small internal RAM ("raw" format) or selects one of two built-in formatters. One formatter builds the one-byte timestamp on/off payload. The other builds the five-byte clock-source payload from a source flag and a 32-bit rate.

A one-cycle `start` launches a frame and `busy` stays high until the last check byte has been accepted. A one-cycle `done` then marks completion. The output side is a valid/ready pair that moves one byte per cycle while ready is high. `flush` drops the frame in progress at any point. A raw request whose length exceeds the limit produces no frame and raises `len_err` instead.

Top module: `pkt_framer_tx`

## Requirements
- R1: A frame is sent as the byte 0x82, then the command byte, then the length byte, then the payload bytes in order (payload RAM address 0 upward), then the low check byte, then the high check byte. The first byte presented after idle is always 0x82.
- R2: Number the command byte 0, the length byte 1 and payload byte i as i+2. The low check byte is the bitwise inverse of the XOR of all bytes with even numbers: the command byte and payload bytes 0, 2, 4 and so on.
- R3: The high check byte is the bitwise inverse of the XOR of all bytes with odd numbers: the length byte and payload bytes 1, 3, 5 and so on.
- R4: A byte is transferred only in a cycle where `tx_valid` and `tx_ready` are both high. While `tx_valid` is high and `tx_ready` is low, `tx_valid` and `tx_data` hold their values. The host must not rewrite the payload RAM during a frame.
- R5: `start` is sampled only when the block is idle, and `busy` is high from the cycle after an accepted `start`. A `start` raised while busy has no effect on the frame in progress.
- R6: In raw format, a `start` with `cmd_len` above 60 sends nothing. `busy` stays low, and `len_err` is high for exactly the one cycle after that `start`.
- R7: `done` is high for exactly one cycle, the cycle after the high check byte is transferred, and `busy` is already low in that cycle.
- R8: A high `flush` returns the block to idle on the next cycle (`tx_valid` and `busy` low, no `done`) without sending check bytes. The next frame is computed afresh.
- R9: With `fmt_sel` = 1, the frame carries command 1, length 1 and the payload byte {7'b0, `tc_on`}. `cmd_code`, `cmd_len` and the RAM are ignored.
- R10: With `fmt_sel` = 2, the frame carries command 2 and length 5. Payload byte 0 is 0 for the internal source and 1 for the external source (`clk_ext`). Bytes 1 to 4 are `clk_rate_hz`, least significant byte first. `fmt_sel` values 0 and 3 select the raw format.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Abandon the frame in progress |
| start | input | 1 | Launch a frame (sampled when idle) |
| fmt_sel | input | 2 | 0/3 raw, 1 timestamp on/off, 2 clock source |
| cmd_code | input | 8 | Command byte for the raw format |
| cmd_len | input | 8 | Payload length for the raw format |
| tc_on | input | 1 | Timestamp enable value for format 1 |
| clk_ext | input | 1 | Clock source flag for format 2 |
| clk_rate_hz | input | 32 | Clock rate in Hz for format 2 |
| pl_wr_en | input | 1 | Payload RAM write enable |
| pl_wr_addr | input | 6 | Payload RAM write address |
| pl_wr_data | input | 8 | Payload RAM write data |
| tx_data | output | 8 | Outgoing byte |
| tx_valid | output | 1 | Outgoing byte is valid |
| tx_ready | input | 1 | Downstream accepts a byte |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle frame completion pulse |
| len_err | output | 1 | One-cycle pulse on a rejected length |

## Verification
The bench sweeps every raw length from 0 to 60 under a pseudo-random ready pattern and compares each frame with one built arithmetically. An empty payload would expose a design that enters the payload phase anyway and sends a stray byte. Odd and even lengths would expose swapped check-byte parity or a byte counted twice under back-pressure. Lengths 61 and 255 must produce no bytes at all, so a design that clamps or truncates fails. A long ready-low stall must leave data frozen and nothing transferred. A start while busy would corrupt the frame or add a second `done`. A flush in mid-frame must stop without check bytes, and the frame after it would carry wrong check bytes if the accumulators were not cleared. The formatter frames check the byte order of the rate field, which fails if the rate is sent most significant byte first.

// File: rtl/pkt_framer_pkg.sv
package pkt_framer_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_MARK,
        ST_CMD,
        ST_LEN,
        ST_PAY,
        ST_CKL,
        ST_CKH
    } tx_state_e;

    typedef enum logic [1:0] {
        FMT_RAW     = 2'd0,
        FMT_TSTAMP  = 2'd1,
        FMT_CLKSRC  = 2'd2,
        FMT_RAW_ALT = 2'd3
    } pay_fmt_e;

    localparam logic [7:0] FRAME_MARK     = 8'h82;
    localparam logic [7:0] CMD_TSTAMP_EN  = 8'h01;
    localparam logic [7:0] CMD_CLK_SOURCE = 8'h02;
    localparam logic [7:0] LEN_TSTAMP     = 8'd1;

endpackage

// File: rtl/pkt_payload_ram.sv
module pkt_payload_ram #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem_q [DEPTH];

    // Host-side write port; contents are not reset
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_q[wr_addr] <= wr_data;
        end
    end

    // Combinational read so the payload byte is ready in its own cycle
    assign rd_data = mem_q[rd_addr];

endmodule

// File: rtl/pkt_payload_fmt.sv
module pkt_payload_fmt
    import pkt_framer_pkg::*;
#(
    parameter int ADDR_W     = 6,
    parameter int RATE_BYTES = 4,
    localparam int RATE_W    = 8 * RATE_BYTES
) (
    input  pay_fmt_e          fmt,
    input  logic [ADDR_W-1:0] idx,
    input  logic [7:0]        ram_byte,
    input  logic              tc_on,
    input  logic              clk_ext,
    input  logic [RATE_W-1:0] rate,
    output logic [7:0]        pay_byte
);
    // R9 / R10: payload byte for the selected formatter at payload index idx
    always_comb begin
        pay_byte = ram_byte;
        case (fmt)
            FMT_TSTAMP: begin
                pay_byte = {7'd0, tc_on};
            end
            FMT_CLKSRC: begin
                pay_byte = {7'd0, clk_ext};
                for (int b = 0; b < RATE_BYTES; b++) begin
                    if (idx == ADDR_W'(b + 1)) begin
                        pay_byte = rate[8*b +: 8];
                    end
                end
            end
            default: pay_byte = ram_byte;
        endcase
    end

endmodule

// File: rtl/pkt_check_acc.sv
module pkt_check_acc (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       upd,
    input  logic [7:0] byte_in,
    output logic [7:0] ck_lo,
    output logic [7:0] ck_hi
);
    typedef struct packed {
        logic       odd;
        logic [7:0] lo;
        logic [7:0] hi;
    } acc_t;

    acc_t acc_d, acc_q;

    // Even-numbered bytes fold into lo, odd-numbered into hi (R2, R3)
    always_comb begin
        acc_d = acc_q;
        if (clr) begin
            acc_d = '0;
        end else if (upd) begin
            if (acc_q.odd) begin
                acc_d.hi = acc_q.hi ^ byte_in;
            end else begin
                acc_d.lo = acc_q.lo ^ byte_in;
            end
            acc_d.odd = ~acc_q.odd;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else begin
            acc_q <= acc_d;
        end
    end

    assign ck_lo = ~acc_q.lo;
    assign ck_hi = ~acc_q.hi;

    // R2/R3: each folded byte moves the parity to the other accumulator
    a_r3_parity_alternates: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && !clr) |=> (acc_q.odd != $past(acc_q.odd)));

    // R8: a clear leaves both check values at the empty-frame result
    a_r8_clear_fresh: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (ck_lo == 8'hFF && ck_hi == 8'hFF && !acc_q.odd));

endmodule

// File: rtl/pkt_framer_tx.sv
module pkt_framer_tx
    import pkt_framer_pkg::*;
#(
    parameter int MAX_LEN    = 60,
    parameter int RATE_BYTES = 4,
    localparam int ADDR_W    = $clog2(MAX_LEN),
    localparam int RATE_W    = 8 * RATE_BYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              start,
    input  logic [1:0]        fmt_sel,
    input  logic [7:0]        cmd_code,
    input  logic [7:0]        cmd_len,
    input  logic              tc_on,
    input  logic              clk_ext,
    input  logic [RATE_W-1:0] clk_rate_hz,
    input  logic              pl_wr_en,
    input  logic [ADDR_W-1:0] pl_wr_addr,
    input  logic [7:0]        pl_wr_data,
    output logic [7:0]        tx_data,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic              busy,
    output logic              done,
    output logic              len_err
);
    localparam logic [7:0] MAX_LEN_B    = 8'(MAX_LEN);
    localparam logic [7:0] LEN_CLKSRC   = 8'(RATE_BYTES + 1);

    typedef struct packed {
        tx_state_e         st;
        logic [7:0]        cmd;
        logic [7:0]        len;
        logic [ADDR_W-1:0] idx;
        pay_fmt_e          fmt;
        logic              tc_on;
        logic              clk_ext;
        logic [RATE_W-1:0] rate;
        logic              done;
        logic              err;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [7:0]        eff_cmd;
    logic [7:0]        eff_len;
    pay_fmt_e          req_fmt;
    logic [ADDR_W-1:0] pay_last;
    logic [7:0]        ram_byte;
    logic [7:0]        pay_byte;
    logic [7:0]        ck_lo;
    logic [7:0]        ck_hi;
    logic              acc_clr;
    logic              acc_upd;

    // Payload storage written by the host
    pkt_payload_ram #(
        .ADDR_W (ADDR_W),
        .DATA_W (8)
    ) u_ram (
        .clk     (clk),
        .wr_en   (pl_wr_en),
        .wr_addr (pl_wr_addr),
        .wr_data (pl_wr_data),
        .rd_addr (ctl_q.idx),
        .rd_data (ram_byte)
    );

    // Formatter for the built-in payload kinds
    pkt_payload_fmt #(
        .ADDR_W     (ADDR_W),
        .RATE_BYTES (RATE_BYTES)
    ) u_fmt (
        .fmt      (ctl_q.fmt),
        .idx      (ctl_q.idx),
        .ram_byte (ram_byte),
        .tc_on    (ctl_q.tc_on),
        .clk_ext  (ctl_q.clk_ext),
        .rate     (ctl_q.rate),
        .pay_byte (pay_byte)
    );

    // Running check bytes
    pkt_check_acc u_ck (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (acc_clr),
        .upd     (acc_upd),
        .byte_in (tx_data),
        .ck_lo   (ck_lo),
        .ck_hi   (ck_hi)
    );

    // Command and length actually framed for the requested format
    always_comb begin
        req_fmt = pay_fmt_e'(fmt_sel);
        case (req_fmt)
            FMT_TSTAMP: begin
                eff_cmd = CMD_TSTAMP_EN;
                eff_len = LEN_TSTAMP;
            end
            FMT_CLKSRC: begin
                eff_cmd = CMD_CLK_SOURCE;
                eff_len = LEN_CLKSRC;
            end
            default: begin
                eff_cmd = cmd_code;
                eff_len = cmd_len;
            end
        endcase
    end

    assign pay_last = ADDR_W'(ctl_q.len) - ADDR_W'(1);

    // Output byte mux (R1)
    always_comb begin
        case (ctl_q.st)
            ST_MARK: tx_data = FRAME_MARK;
            ST_CMD:  tx_data = ctl_q.cmd;
            ST_LEN:  tx_data = ctl_q.len;
            ST_PAY:  tx_data = pay_byte;
            ST_CKL:  tx_data = ck_lo;
            ST_CKH:  tx_data = ck_hi;
            default: tx_data = 8'h00;
        endcase
    end

    assign tx_valid = (ctl_q.st != ST_IDLE);
    assign busy     = tx_valid;
    assign done     = ctl_q.done;
    assign len_err  = ctl_q.err;

    // Bytes numbered into the check bytes: command, length, payload
    assign acc_upd = tx_ready && !flush &&
                     (ctl_q.st == ST_CMD || ctl_q.st == ST_LEN || ctl_q.st == ST_PAY);

    // Next-state logic
    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        ctl_d.err  = 1'b0;
        acc_clr    = 1'b0;
        if (flush) begin
            // R8: drop the frame at once
            ctl_d.st  = ST_IDLE;
            ctl_d.idx = '0;
            acc_clr   = 1'b1;
        end else begin
            case (ctl_q.st)
                ST_IDLE: begin
                    if (start) begin
                        if (eff_len > MAX_LEN_B) begin
                            ctl_d.err = 1'b1;         // R6
                        end else begin
                            ctl_d.st      = ST_MARK;  // R5
                            ctl_d.cmd     = eff_cmd;
                            ctl_d.len     = eff_len;
                            ctl_d.fmt     = req_fmt;
                            ctl_d.tc_on   = tc_on;
                            ctl_d.clk_ext = clk_ext;
                            ctl_d.rate    = clk_rate_hz;
                            ctl_d.idx     = '0;
                            acc_clr       = 1'b1;
                        end
                    end
                end
                ST_MARK: if (tx_ready) ctl_d.st = ST_CMD;
                ST_CMD:  if (tx_ready) ctl_d.st = ST_LEN;
                ST_LEN: begin
                    if (tx_ready) begin
                        ctl_d.idx = '0;
                        ctl_d.st  = (ctl_q.len == 8'd0) ? ST_CKL : ST_PAY;
                    end
                end
                ST_PAY: begin
                    if (tx_ready) begin
                        if (ctl_q.idx == pay_last) begin
                            ctl_d.st = ST_CKL;
                        end else begin
                            ctl_d.idx = ctl_q.idx + ADDR_W'(1);
                        end
                    end
                end
                ST_CKL:  if (tx_ready) ctl_d.st = ST_CKH;
                ST_CKH: begin
                    if (tx_ready) begin
                        ctl_d.st   = ST_IDLE;
                        ctl_d.done = 1'b1;            // R7
                    end
                end
                default: ctl_d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    a_r1_mark_first: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_valid) |-> (tx_data == FRAME_MARK));

    a_r4_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready && !flush) |=> (tx_valid && $stable(tx_data)));

    a_r5_busy_from_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    a_r6_err_no_frame: assert property (@(posedge clk) disable iff (!rst_n)
        len_err |-> (!busy && !tx_valid));

    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r7_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    a_r8_flush_idle: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (!tx_valid && !busy && !done));

endmodule

// File: tb/test_pkt_framer_tx.sv
module test_pkt_framer_tx;
    localparam int MAXL = 60;
    localparam int AW   = $clog2(MAXL);

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  fmt_sel = 2'd0;
    logic [7:0]  cmd_code = 8'h00;
    logic [7:0]  cmd_len = 8'h00;
    logic        tc_on = 1'b0;
    logic        clk_ext = 1'b0;
    logic [31:0] clk_rate_hz = 32'h0;
    logic        pl_wr_en = 1'b0;
    logic [AW-1:0] pl_wr_addr = '0;
    logic [7:0]  pl_wr_data = 8'h00;
    logic [7:0]  tx_data;
    logic        tx_valid;
    logic        tx_ready;
    logic        busy;
    logic        done;
    logic        len_err;

    pkt_framer_tx #(.MAX_LEN(MAXL), .RATE_BYTES(4)) i_pkt_framer_tx (
        .clk(clk), .rst_n(rst_n), .flush(flush), .start(start),
        .fmt_sel(fmt_sel), .cmd_code(cmd_code), .cmd_len(cmd_len),
        .tc_on(tc_on), .clk_ext(clk_ext), .clk_rate_hz(clk_rate_hz),
        .pl_wr_en(pl_wr_en), .pl_wr_addr(pl_wr_addr), .pl_wr_data(pl_wr_data),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .busy(busy), .done(done), .len_err(len_err)
    );

    always #10 clk = ~clk;   // 50 MHz

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    logic [7:0] cap [0:127];
    logic [7:0] exp_b [0:127];
    logic [7:0] exp_pl [0:63];
    int ncap = 0;
    int nexp = 0;
    int ndone = 0;
    int nerr = 0;
    bit done_bad = 1'b0;
    bit rdy_force_lo = 1'b0;
    bit rdy_all = 1'b0;
    logic [15:0] lfsr = 16'hACE1;

    // Ready pattern, updated shortly after each rising edge
    initial begin
        tx_ready = 1'b0;
        forever begin
            @(posedge clk);
            #1;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            tx_ready = rdy_force_lo ? 1'b0 : (rdy_all ? 1'b1 : (lfsr[0] | lfsr[3]));
        end
    end

    // Monitor at the falling edge: bytes transferred at the coming edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (tx_valid && tx_ready) begin
                if (ncap < 128) cap[ncap] = tx_data;
                ncap++;
            end
            if (done) begin
                ndone++;
                if (busy) done_bad = 1'b1;
            end
            if (len_err) nerr++;
        end
    end

    task automatic summary();
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
        end
    end

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    // Expected frame from the requirement arithmetic (R1, R2, R3)
    task automatic build_exp(input logic [7:0] c, input int l);
        logic [7:0] lo;
        logic [7:0] hi;
        lo = c;
        hi = 8'(l);
        exp_b[0] = 8'h82;
        exp_b[1] = c;
        exp_b[2] = 8'(l);
        for (int i = 0; i < l; i++) begin
            exp_b[3 + i] = exp_pl[i];
            if (i % 2 == 0) lo = lo ^ exp_pl[i];
            else            hi = hi ^ exp_pl[i];
        end
        exp_b[3 + l] = ~lo;
        exp_b[4 + l] = ~hi;
        nexp = l + 5;
    endtask

    task automatic cmp_frame(input string req, input string what);
        int bad;
        bad = -1;
        if (ncap != nexp) begin
            chk(1'b0, req, {what, " byte count"}, ncap, nexp);
        end else begin
            for (int k = 0; k < nexp; k++) begin
                if (bad < 0 && cap[k] !== exp_b[k]) bad = k;
            end
            if (bad >= 0)
                chk(1'b0, req, $sformatf("%s byte %0d", what, bad), cap[bad], exp_b[bad]);
            else
                chk(1'b1, req, what, 0, 0);
        end
    endtask

    task automatic load_ram(input int l);
        for (int i = 0; i < l; i++) begin
            pl_wr_en   = 1'b1;
            pl_wr_addr = AW'(i);
            pl_wr_data = exp_pl[i];
            step();
        end
        pl_wr_en = 1'b0;
    endtask

    task automatic wait_done(input int lim);
        int t;
        t = 0;
        while (ndone == 0 && t < lim) begin
            step();
            t++;
        end
        step();
        step();
    endtask

    task automatic send(input logic [1:0] f, input logic [7:0] c, input logic [7:0] l,
                        input logic tco, input logic ext, input logic [31:0] rate);
        ncap = 0;
        ndone = 0;
        nerr = 0;
        done_bad = 1'b0;
        fmt_sel = f;
        cmd_code = c;
        cmd_len = l;
        tc_on = tco;
        clk_ext = ext;
        clk_rate_hz = rate;
        start = 1'b1;
        step();
        start = 1'b0;
        chk(busy === 1'b1, "R5", "busy after start", busy, 1);
        wait_done(3000);
    endtask

    task automatic clk_frame(input logic ext, input logic [31:0] rate);
        exp_pl[0] = {7'd0, ext};
        for (int b = 0; b < 4; b++) exp_pl[1 + b] = rate[8*b +: 8];
        send(2'd2, 8'hEE, 8'd63, 1'b0, ext, rate);
        build_exp(8'h02, 5);
        cmp_frame("R10", $sformatf("clock source ext=%0d rate=%0d", ext, rate));
        chk(nerr == 0 && ndone == 1, "R10", "no error, one done", nerr, 0);
    endtask

    initial begin
        int nc;
        logic [7:0] d0;
        // Reset state
        repeat (3) step();
        chk(tx_valid === 1'b0 && busy === 1'b0 && done === 1'b0 && len_err === 1'b0,
            "R1", "reset outputs idle", {tx_valid, busy, done, len_err}, 0);
        rst_n = 1'b1;
        step();

        // R1/R2/R3/R7: every raw length under random back-pressure
        for (int l = 0; l <= MAXL; l++) begin
            for (int i = 0; i < l; i++) exp_pl[i] = 8'((i * 29 + l * 7 + 3) & 255);
            load_ram(l);
            send(2'd0, 8'(l * 5 + 16), 8'(l), 1'b0, 1'b0, 32'h0);
            build_exp(8'(l * 5 + 16), l);
            cmp_frame("R1 R2 R3", $sformatf("raw length %0d", l));
            chk(ndone == 1 && !done_bad, "R7", $sformatf("single done, len %0d", l), ndone, 1);
        end

        // R10: alternate raw code 3
        for (int i = 0; i < 4; i++) exp_pl[i] = 8'(8'hA0 + i);
        load_ram(4);
        send(2'd3, 8'h5A, 8'd4, 1'b1, 1'b1, 32'hFFFF_FFFF);
        build_exp(8'h5A, 4);
        cmp_frame("R10", "format code 3 is raw");

        // R6: over-limit lengths
        for (int k = 0; k < 2; k++) begin
            ncap = 0;
            nerr = 0;
            fmt_sel = 2'd0;
            cmd_code = 8'h33;
            cmd_len = (k == 0) ? 8'd61 : 8'd255;
            start = 1'b1;
            step();
            start = 1'b0;
            chk(len_err === 1'b1 && busy === 1'b0, "R6", "error pulse, not busy",
                {len_err, busy}, 2'b10);
            step();
            chk(len_err === 1'b0, "R6", "error is one cycle", len_err, 0);
            repeat (10) step();
            chk(ncap == 0 && nerr == 1, "R6", $sformatf("no bytes for len %0d", cmd_len), ncap, 0);
        end

        // R5: start while busy is ignored
        for (int i = 0; i < 10; i++) exp_pl[i] = 8'(i * 17 + 1);
        load_ram(10);
        ncap = 0; ndone = 0; done_bad = 1'b0;
        fmt_sel = 2'd0; cmd_code = 8'h31; cmd_len = 8'd10;
        start = 1'b1;
        step();
        start = 1'b0;
        repeat (4) step();
        cmd_code = 8'h77; cmd_len = 8'd3;
        start = 1'b1;
        step();
        start = 1'b0;
        wait_done(3000);
        build_exp(8'h31, 10);
        cmp_frame("R5", "frame unchanged by start while busy");
        chk(ndone == 1, "R5", "only one frame", ndone, 1);

        // R4: stall with ready low
        for (int i = 0; i < 20; i++) exp_pl[i] = 8'(255 - i * 3);
        load_ram(20);
        ncap = 0; ndone = 0;
        rdy_all = 1'b1;
        cmd_code = 8'h44; cmd_len = 8'd20; fmt_sel = 2'd0;
        start = 1'b1;
        step();
        start = 1'b0;
        repeat (5) step();
        rdy_force_lo = 1'b1;
        step();
        step();
        nc = ncap;
        d0 = tx_data;
        repeat (15) step();
        chk(ncap == nc && tx_data == d0 && tx_valid === 1'b1, "R4", "stall holds data",
            tx_data, d0);
        rdy_force_lo = 1'b0;
        wait_done(3000);
        build_exp(8'h44, 20);
        cmp_frame("R4", "frame after stall");

        // R8: flush mid-frame
        for (int i = 0; i < 40; i++) exp_pl[i] = 8'(i * 11 + 9);
        load_ram(40);
        ncap = 0; ndone = 0;
        cmd_code = 8'h66; cmd_len = 8'd40;
        start = 1'b1;
        step();
        start = 1'b0;
        repeat (8) step();
        flush = 1'b1;
        step();
        flush = 1'b0;
        chk(tx_valid === 1'b0 && busy === 1'b0, "R8", "idle after flush", {tx_valid, busy}, 0);
        nc = ncap;
        repeat (6) step();
        build_exp(8'h66, 40);
        chk(ndone == 0 && ncap == nc && ncap < nexp - 2, "R8", "no done, no check bytes", ncap, nc);
        begin
            int bad;
            bad = -1;
            for (int k = 0; k < ncap; k++) if (bad < 0 && cap[k] !== exp_b[k]) bad = k;
            chk(bad < 0, "R8", "flushed bytes are a prefix", bad, -1);
        end
        for (int i = 0; i < 7; i++) exp_pl[i] = 8'(i + 100);
        load_ram(7);
        rdy_all = 1'b0;
        send(2'd0, 8'h21, 8'd7, 1'b0, 1'b0, 32'h0);
        build_exp(8'h21, 7);
        cmp_frame("R8", "fresh frame after flush");

        // R9: timestamp on/off
        for (int v = 0; v < 2; v++) begin
            exp_pl[0] = 8'(v);
            send(2'd1, 8'hCC, 8'd200, v[0], 1'b0, 32'h0);
            build_exp(8'h01, 1);
            cmp_frame("R9", $sformatf("timestamp enable %0d", v));
            chk(nerr == 0, "R9", "raw length ignored", nerr, 0);
        end

        // R10: clock-source payloads
        clk_frame(1'b0, 32'd1000000);
        clk_frame(1'b0, 32'd8000000);
        clk_frame(1'b0, 32'd12000000);
        clk_frame(1'b0, 32'd16000000);
        clk_frame(1'b1, 32'd10000000);

        summary();
    end

endmodule